// File: doc/BRIEF.md
# Two-Edge Capture Register

This block is a register that takes a new value on every clock transition, low-to-high and high-to-low alike, while being built only from ordinary single-edge flops. Each bit has two storage halves. One half changes only on rising edges and the other only on falling edges. The visible output is the exclusive-or of the two halves.

On each edge, the half that owns that edge compares the incoming data with the output it currently sees. It flips its stored bit only where the two differ. After the edge, the exclusive-or therefore equals the captured data, and the other half needs no change. A designer uses the block where data arrives at twice the clock rate and must be held for half a period.

The output passes through a gate after the flops, and each flop's next state depends on the output. Because of this, the block suits paths with relaxed timing and not tight fully synchronous ones. Reset is synchronous and active low. Each half clears on its own edge, so the output is zero once one rising and one falling edge have both seen reset.

Top module: `dual_edge_reg`

## Requirements
- R1: After a rising clock edge at which `rst_n` is high, `q_out` equals the value `d_in` held at that edge, and it keeps that value until the next falling edge.
- R2: After a falling clock edge at which `rst_n` is high, `q_out` equals the value `d_in` held at that edge, and it keeps that value until the next rising edge.
- R3: Reset is synchronous and active low. Each half clears only on its own edge. Once a rising and a falling edge have both occurred with `rst_n` low, `q_out` is all zeros. The first edge after release, of either polarity, captures `d_in` as in R1 or R2.
- R4: The bits are independent. Bit i of `q_out` depends only on bit i of `d_in`, for every bit of the `DATA_W`-bit bus (default 8).
- R5: A change of `d_in` between two edges has no effect on `q_out` until the next edge.
- R6: Capturing the same value on consecutive edges leaves `q_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Both of its edges capture data |
| rst_n | input | 1 | Synchronous reset, active low, sampled on each half's own edge |
| d_in | input | DATA_W | Data to capture |
| q_out | output | DATA_W | Most recently captured data |

## Verification
Reset and capture can fall within the same clock period. The bench raises `rst_n` between a rising edge that still saw reset and the following falling edge. That falling edge must then capture `d_in` while the rising half still holds zero, and the output is judged against the driven data at once. The bench also drives a fresh value into every half period so that the two halves capture different data within one cycle. Every edge is checked against the value driven just before it, and the data is disturbed mid-phase to confirm that only edges move the output.

// File: rtl/dual_edge_pkg.sv
// Package: shared helpers for the two-edge capture register.
// Assumes per-bit operation; every helper works bitwise on DATA vectors.
package dual_edge_pkg;

    // Bits where the freshly presented data differs from the visible output:
    // these are the bits a storage half must flip on its own edge.
    function automatic logic [63:0] flip_mask(input logic [63:0] data_v,
                                              input logic [63:0] vis_v);
        return data_v ^ vis_v;
    endfunction

endpackage

// File: rtl/dual_edge_half.sv
// Module: one storage half of the two-edge register.
// FALL_EDGE selects which clock edge the half responds to. On its edge the
// half flips each stored bit where d_in differs from the visible output, so
// the visible XOR afterwards equals d_in. Assumes vis_q is the XOR of this
// half and its partner. Reset is synchronous, active low, on the own edge.
module dual_edge_half
    import dual_edge_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic [DATA_W-1:0] vis_q,
    output logic [DATA_W-1:0] half_q
);

    localparam int PAD_W = 64 - DATA_W;

    logic [DATA_W-1:0] flip_v;
    logic [63:0]       mask_wide;

    // Purpose: compute which bits must change on this half's edge.
    always_comb begin
        mask_wide = flip_mask({{PAD_W{1'b0}}, d_in}, {{PAD_W{1'b0}}, vis_q});
        flip_v    = mask_wide[DATA_W-1:0];
    end

    generate
        if (FALL_EDGE) begin : g_fall
            // Purpose: falling-edge storage with synchronous clear.
            always_ff @(negedge clk) begin
                if (!rst_n) half_q <= '0;
                else        half_q <= half_q ^ flip_v;
            end
        end else begin : g_rise
            // Purpose: rising-edge storage with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) half_q <= '0;
                else        half_q <= half_q ^ flip_v;
            end
        end
    endgenerate

endmodule

// File: rtl/dual_edge_merge.sv
// Module: combines the two storage halves into the visible value.
// Assumes both inputs come straight from the storage halves.
module dual_edge_merge #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rise_q,
    input  logic [DATA_W-1:0] fall_q,
    output logic [DATA_W-1:0] vis_q
);

    // Purpose: the visible value is the bitwise XOR of the halves.
    always_comb vis_q = rise_q ^ fall_q;

endmodule

// File: rtl/dual_edge_reg.sv
// Module: register capturing d_in on both clock edges.
// Built from a rising-edge half, a falling-edge half and an XOR merge whose
// output feeds back to both halves. Assumes a clock with roughly even duty
// and relaxed timing on the output path. Reset: synchronous, active low.
module dual_edge_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q_out
);

    logic [DATA_W-1:0] rise_q;
    logic [DATA_W-1:0] fall_q;

    dual_edge_half #(.DATA_W(DATA_W), .FALL_EDGE(1'b0)) rise_half_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (d_in),
        .vis_q  (q_out),
        .half_q (rise_q)
    );

    dual_edge_half #(.DATA_W(DATA_W), .FALL_EDGE(1'b1)) fall_half_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (d_in),
        .vis_q  (q_out),
        .half_q (fall_q)
    );

    dual_edge_merge #(.DATA_W(DATA_W)) merge_i (
        .rise_q (rise_q),
        .fall_q (fall_q),
        .vis_q  (q_out)
    );

endmodule

// File: rtl/dual_edge_reg_chk.sv
// Checker: watches the ports of dual_edge_reg on both clock edges.
module dual_edge_reg_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] d_in,
    input logic [DATA_W-1:0] q_out
);

    bit [DATA_W-1:0] cap_rise;
    bit [DATA_W-1:0] cap_fall;
    bit              live_rise;
    bit              live_fall;
    bit              rst_rise;
    bit              rst_fall;

    // Purpose: record data and reset seen at each rising edge.
    always_ff @(posedge clk) begin
        cap_rise  <= d_in;
        live_rise <= rst_n;
        rst_rise  <= !rst_n;
    end

    // Purpose: record data and reset seen at each falling edge.
    always_ff @(negedge clk) begin
        cap_fall  <= d_in;
        live_fall <= rst_n;
        rst_fall  <= !rst_n;
    end

    assert_rise_capture_R1: assert property (@(negedge clk) disable iff (!rst_n)
        live_rise |-> (q_out == cap_rise));

    assert_fall_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_fall |-> (q_out == cap_fall));

    // R3: both halves were cleared on their latest own edges.
    always @(negedge clk) begin
        if (rst_rise && rst_fall)
            assert_reset_at_fall_R3: assert (q_out == '0);
    end

    always @(posedge clk) begin
        if (rst_rise && rst_fall)
            assert_reset_at_rise_R3: assert (q_out == '0);
    end

endmodule

bind dual_edge_reg dual_edge_reg_chk #(.DATA_W(DATA_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (d_in),
    .q_out (q_out)
);

// File: tb/dual_edge_reg_tb_top.sv
`timescale 1ns/1ps
module dual_edge_reg_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q_out;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    dual_edge_reg #(.DATA_W(W)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (d_in),
        .q_out (q_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive v, wait for the next edge of either kind, check 1 ns later.
    task automatic step(input logic [W-1:0] v);
        d_in = v;
        @(clk);
        #1;
        if (clk) chk("R1 rising capture", q_out, v);
        else     chk("R2 falling capture", q_out, v);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        d_in  = 8'hA5;
        repeat (3) begin @(clk); #1; end
        chk("R3 reset clears output", q_out, '0);
        d_in = 8'hFF;
        @(clk); #1;
        chk("R3 reset holds under data", q_out, '0);
        @(clk); #1;
        chk("R3 reset holds other edge", q_out, '0);
    endtask

    task automatic t_alternate();
        logic [W-1:0] seq [8] = '{8'h3C, 8'hC3, 8'h01, 8'hFE, 8'h55, 8'hAA, 8'h00, 8'h9B};
        for (int i = 0; i < 8; i++) step(seq[i]);
    endtask

    task automatic t_repeat();
        step(8'h6D);
        step(8'h6D);
        chk("R6 repeated value steady", q_out, 8'h6D);
        step(8'h6D);
        chk("R6 repeated value third edge", q_out, 8'h6D);
    endtask

    task automatic t_ignore();
        for (int i = 0; i < 4; i++) begin
            step(8'h10 + 8'(i));
            d_in = ~(8'h10 + 8'(i));
            #0.8;
            chk("R5 mid-phase change ignored", q_out, 8'h10 + 8'(i));
        end
    endtask

    task automatic t_lanes();
        step('0);
        for (int b = 0; b < W; b++) step(8'(1) << b);
        for (int b = 0; b < W; b++) step(~(8'(1) << b));
        chk("R4 last lane pattern", q_out, ~(8'(1) << (W - 1)));
    endtask

    // Release reset between edges: the next edge, of whichever kind, captures.
    task automatic t_release();
        t_reset();
        rst_n = 1'b1;
        step(8'h77);
        chk("R3 first edge after release", q_out, 8'h77);
        step(8'h88);
        step(8'h99);
    endtask

    initial begin
        @(posedge clk); #1;
        @(negedge clk); #1;
        chk("R3 reset state", q_out, '0);
        t_reset();
        rst_n = 1'b1;
        t_alternate();
        t_repeat();
        t_ignore();
        t_lanes();
        t_release();
        // Release on the opposite phase from the first release.
        t_reset();
        @(clk); #1;
        rst_n = 1'b1;
        step(8'h4E);
        chk("R3 release other phase", q_out, 8'h4E);
        t_alternate();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule